// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block is a circular buffer that turns out-of-order execution into in-order retirement. Each instruction claims a slot when it is dispatched. The slot records the instruction's kind, its destination and an empty result field. The slot index goes back to the dispatcher, which uses it as the result tag. Execution units later send their results on a write-back bus, tagged with that slot index. The buffer stores each result in the matching slot and marks the slot complete.

The oldest slot retires once its result is present, and at most one slot retires per clock. A register result goes out on the register-file write port. A store goes out on the memory write port as an address and data pair. A branch leaves no architectural trace, unless it was mispredicted. A mispredicted branch at the head empties the whole buffer, and so does a faulting instruction at the head. A faulting instruction also raises a precise exception, and only when it reaches the head.

A producer table holds one pointer per architectural register, naming the newest in-flight slot that will write that register. A newly dispatched instruction looks up its source register here. The table reports whether a producer is still in flight and which slot it is. It also returns the produced value if that slot has completed but has not yet retired. The pointer is cleared when that producer retires, and every pointer is cleared on a flush. The depth must be a power of two.

Top module: `rob_commit`

## Requirements
- R1: After reset the buffer is empty: `disp_ready` is 1, `disp_tag` is 0, no commit, flush or exception output is active, and every register lookup reports `src_pending` = 0.
- R2: An accepted dispatch takes the slot shown on `disp_tag`, and the following dispatches receive consecutive slot numbers that wrap modulo DEPTH.
- R3: When DEPTH slots are occupied, `disp_ready` is 0 and a dispatch request is ignored.
- R4: Retirement is strictly oldest-first. A completed younger slot waits behind an incomplete head, and at most one slot retires per clock.
- R5: A head slot of kind register (`disp_kind` = 0) that holds a fault-free result drives `rf_we` = 1 with `rf_waddr` = the low REG_W bits of its destination and `rf_wdata` = its result. This happens in the cycle after its write-back edge.
- R6: A head slot of kind store (`disp_kind` = 1) that holds a fault-free result drives `st_we` = 1 with `st_addr` = its destination and `st_data` = its value, and leaves `rf_we` at 0.
- R7: A lookup of a register whose newest producer is in flight returns `src_pending` = 1 and that producer's slot on `src_tag`. Once that slot has completed, the lookup also returns `src_ready` = 1 and its value on `src_value`.
- R8: Retiring a register producer clears the lookup entry for its register only if no younger in-flight slot writes the same register.
- R9: A completed branch (`disp_kind` = 2) at the head with `wb_mispred` set drives `flush` = 1 without any write. After that edge the buffer is empty, `disp_tag` is 0 and no lookup is pending.
- R10: A slot written back with `wb_exc` = 1 raises `exc_raise` and `flush` when it reaches the head, and produces no register or memory write.
- R11: A correctly predicted branch at the head retires with no write and no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | 0 register write, 1 store, 2 branch |
| disp_dest | input | ADDR_W | Destination register (low REG_W bits) or store address |
| disp_ready | output | 1 | A slot is free and no flush is in progress |
| disp_tag | output | TAG_W | Slot number given to the next dispatch |
| wb_valid | input | 1 | Write-back result valid |
| wb_tag | input | TAG_W | Slot the result belongs to |
| wb_value | input | DATA_W | Result value or store data |
| wb_exc | input | 1 | Result carries a fault |
| wb_mispred | input | 1 | Branch outcome was mispredicted |
| src_reg | input | REG_W | Register being looked up |
| src_pending | output | 1 | An in-flight slot will write src_reg |
| src_tag | output | TAG_W | Newest producer slot of src_reg |
| src_ready | output | 1 | That producer has completed |
| src_value | output | DATA_W | Producer's value when src_ready |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | REG_W | Register written |
| rf_wdata | output | DATA_W | Value written |
| st_we | output | 1 | Memory store strobe |
| st_addr | output | ADDR_W | Store address |
| st_data | output | DATA_W | Store data |
| flush | output | 1 | Buffer is emptied at the next edge |
| exc_raise | output | 1 | Precise exception from the head slot |

## Verification
The first corner case is a younger slot that completes before the head. A design that retired by completion order would write that younger result first and break R4. The second is a register with two producers in flight at once. If the older one retires, a design that cleared the lookup entry without comparing slot numbers would send the consumer to a stale register-file value. The third group is the full buffer, the wrap of slot numbers past DEPTH-1, and a flush on a full buffer. An off-by-one pointer here would either overwrite a live slot or fail to return `disp_tag` to 0. A behavioural queue model is compared against every output on every cycle. It runs through scripted sequences and then long random traffic with faults and mispredictions mixed in.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [1:0] {
        K_REG    = 2'd0,
        K_STORE  = 2'd1,
        K_BRANCH = 2'd2
    } op_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_i,
    input  logic             retire_i,
    input  logic             flush_i,
    output logic [PTR_W-1:0] head_o,
    output logic [PTR_W-1:0] tail_o,
    output logic             full_o
);
    typedef struct packed {
        logic [PTR_W-1:0] head;
        logic [PTR_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (retire_i) st_d.head = bump(st_q.head);
        if (alloc_i)  st_d.tail = bump(st_q.tail);
        if (alloc_i && !retire_i)      st_d.count = st_q.count + CNT_W'(1);
        else if (!alloc_i && retire_i) st_d.count = st_q.count - CNT_W'(1);
        if (flush_i) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o = st_q.head;
    assign tail_o = st_q.tail;
    assign full_o = (st_q.count == CNT_W'(DEPTH));

    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(DEPTH));
    p_no_alloc_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !alloc_i);
    p_tag_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !flush_i) |=> tail_o == bump($past(tail_o)));
    p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (st_q.count == '0 && tail_o == '0));
endmodule

// File: rtl/rob_status_table.sv
module rob_status_table #(
    parameter int REG_W = 5,
    parameter int TAG_W = 3,
    localparam int NREGS = 1 << REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [REG_W-1:0] set_reg_i,
    input  logic [TAG_W-1:0] set_tag_i,
    input  logic             clr_i,
    input  logic [REG_W-1:0] clr_reg_i,
    input  logic [TAG_W-1:0] clr_tag_i,
    input  logic             flush_i,
    input  logic [REG_W-1:0] look_reg_i,
    output logic             look_valid_o,
    output logic [TAG_W-1:0] look_tag_o
);
    typedef struct packed {
        logic [NREGS-1:0]            valid;
        logic [NREGS-1:0][TAG_W-1:0] tag;
    } tbl_state_t;

    tbl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i && st_q.valid[clr_reg_i] && st_q.tag[clr_reg_i] == clr_tag_i)
            st_d.valid[clr_reg_i] = 1'b0;
        if (set_i) begin
            st_d.valid[set_reg_i] = 1'b1;
            st_d.tag[set_reg_i]   = set_tag_i;
        end
        if (flush_i) st_d.valid = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign look_valid_o = st_q.valid[look_reg_i];
    assign look_tag_o   = st_q.tag[look_reg_i];

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> $countones(st_q.valid) == 0);
    p_set_visible_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !flush_i) |=> st_q.valid[$past(set_reg_i)]);
endmodule

// File: rtl/rob_commit.sv
module rob_commit #(
    parameter int DEPTH  = 8,
    parameter int REG_W  = 5,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [1:0]        disp_kind,
    input  logic [ADDR_W-1:0] disp_dest,
    output logic              disp_ready,
    output logic [TAG_W-1:0]  disp_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_exc,
    input  logic              wb_mispred,
    input  logic [REG_W-1:0]  src_reg,
    output logic              src_pending,
    output logic [TAG_W-1:0]  src_tag,
    output logic              src_ready,
    output logic [DATA_W-1:0] src_value,
    output logic              rf_we,
    output logic [REG_W-1:0]  rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              st_we,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data,
    output logic              flush,
    output logic              exc_raise
);
    import rob_pkg::*;

    typedef struct packed {
        logic              busy;
        op_kind_e          kind;
        logic [ADDR_W-1:0] dest;
        logic [DATA_W-1:0] value;
        logic              ready;
        logic              exc;
        logic              mis;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
    } buf_state_t;

    buf_state_t st_d, st_q;
    logic [TAG_W-1:0] head_ptr, tail_ptr;
    logic             full, head_done, alloc;
    slot_t            hd;
    op_kind_e         new_kind;

    assign new_kind  = op_kind_e'(disp_kind);
    assign hd        = st_q.slot[head_ptr];
    assign head_done = hd.busy && hd.ready;
    assign flush     = head_done && (hd.exc || (hd.kind == K_BRANCH && hd.mis));
    assign exc_raise = head_done && hd.exc;
    assign rf_we     = head_done && !hd.exc && hd.kind == K_REG;
    assign rf_waddr  = hd.dest[REG_W-1:0];
    assign rf_wdata  = hd.value;
    assign st_we     = head_done && !hd.exc && hd.kind == K_STORE;
    assign st_addr   = hd.dest;
    assign st_data   = hd.value;
    assign disp_ready = !full && !flush;
    assign alloc      = disp_valid && disp_ready;
    assign disp_tag   = tail_ptr;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_i  (alloc),
        .retire_i (head_done),
        .flush_i  (flush),
        .head_o   (head_ptr),
        .tail_o   (tail_ptr),
        .full_o   (full)
    );

    rob_status_table #(.REG_W(REG_W), .TAG_W(TAG_W)) u_tbl (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_i        (alloc && new_kind == K_REG),
        .set_reg_i    (disp_dest[REG_W-1:0]),
        .set_tag_i    (tail_ptr),
        .clr_i        (head_done && hd.kind == K_REG),
        .clr_reg_i    (hd.dest[REG_W-1:0]),
        .clr_tag_i    (head_ptr),
        .flush_i      (flush),
        .look_reg_i   (src_reg),
        .look_valid_o (src_pending),
        .look_tag_o   (src_tag)
    );

    assign src_ready = src_pending && st_q.slot[src_tag].ready;
    assign src_value = src_ready ? st_q.slot[src_tag].value : '0;

    always_comb begin
        st_d = st_q;
        if (wb_valid && st_q.slot[wb_tag].busy) begin
            st_d.slot[wb_tag].ready = 1'b1;
            st_d.slot[wb_tag].value = wb_value;
            st_d.slot[wb_tag].exc   = wb_exc;
            st_d.slot[wb_tag].mis   = wb_mispred;
        end
        if (head_done) st_d.slot[head_ptr].busy = 1'b0;
        if (alloc) begin
            st_d.slot[tail_ptr].busy  = 1'b1;
            st_d.slot[tail_ptr].kind  = new_kind;
            st_d.slot[tail_ptr].dest  = disp_dest;
            st_d.slot[tail_ptr].value = '0;
            st_d.slot[tail_ptr].ready = 1'b0;
            st_d.slot[tail_ptr].exc   = 1'b0;
            st_d.slot[tail_ptr].mis   = 1'b0;
        end
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) st_d.slot[i].busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: one retirement action per cycle
    p_commit_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, st_we, flush}));
    p_lookup_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        src_pending |-> st_q.slot[src_tag].busy);
    p_head_leaves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (head_done && !flush) |=> head_ptr != $past(head_ptr));
endmodule

// File: tb/rob_commit_test.sv
`timescale 1ns/1ps
module rob_commit_test;
    localparam int DEPTH = 8, REG_W = 5, ADDR_W = 16, DATA_W = 32, TAG_W = 3;
    localparam int NREGS = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic disp_valid = 0; logic [1:0] disp_kind = 0; logic [ADDR_W-1:0] disp_dest = 0;
    logic disp_ready; logic [TAG_W-1:0] disp_tag;
    logic wb_valid = 0; logic [TAG_W-1:0] wb_tag = 0; logic [DATA_W-1:0] wb_value = 0;
    logic wb_exc = 0, wb_mispred = 0;
    logic [REG_W-1:0] src_reg = 0;
    logic src_pending, src_ready; logic [TAG_W-1:0] src_tag; logic [DATA_W-1:0] src_value;
    logic rf_we, st_we, flush, exc_raise;
    logic [REG_W-1:0] rf_waddr; logic [DATA_W-1:0] rf_wdata, st_data; logic [ADDR_W-1:0] st_addr;

    always #2.5 clk = ~clk;

    rob_commit #(.DEPTH(DEPTH), .REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_kind(disp_kind),
        .disp_dest(disp_dest), .disp_ready(disp_ready), .disp_tag(disp_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value), .wb_exc(wb_exc),
        .wb_mispred(wb_mispred), .src_reg(src_reg), .src_pending(src_pending),
        .src_tag(src_tag), .src_ready(src_ready), .src_value(src_value),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .st_we(st_we),
        .st_addr(st_addr), .st_data(st_data), .flush(flush), .exc_raise(exc_raise));

    int checks = 0, failures = 0;
    bit done = 0;

    typedef struct {int tag; int kind; int dest; int val; bit rdy; bit exc; bit mis;} ment_t;
    ment_t mq[$];
    int rat[NREGS];
    int ntag;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_done(); return mq.size() > 0 && mq[0].rdy; endfunction
    function automatic bit m_flush();
        return m_done() && (mq[0].exc || (mq[0].kind == 2 && mq[0].mis));
    endfunction

    task automatic model_reset();
        mq.delete(); ntag = 0;
        foreach (rat[i]) rat[i] = -1;
    endtask

    task automatic model_update();
        bit hdn, fl, acc;
        hdn = m_done(); fl = m_flush();
        acc = disp_valid && mq.size() < DEPTH && !fl;
        if (wb_valid)
            foreach (mq[i]) if (mq[i].tag == int'(wb_tag)) begin
                mq[i].rdy = 1; mq[i].val = int'(wb_value);
                mq[i].exc = wb_exc; mq[i].mis = wb_mispred;
            end
        if (hdn) begin
            if (mq[0].kind == 0 && rat[mq[0].dest % NREGS] == mq[0].tag) rat[mq[0].dest % NREGS] = -1;
            void'(mq.pop_front());
        end
        if (fl) begin
            mq.delete(); ntag = 0;
            foreach (rat[i]) rat[i] = -1;
        end
        if (acc) begin
            ment_t e;
            e.tag = ntag; e.kind = int'(disp_kind); e.dest = int'(disp_dest);
            e.val = 0; e.rdy = 0; e.exc = 0; e.mis = 0;
            mq.push_back(e);
            if (e.kind == 0) rat[e.dest % NREGS] = ntag;
            ntag = (ntag + 1) % DEPTH;
        end
    endtask

    task automatic compare();
        bit hdn, fl, ewe, esw; int r;
        hdn = m_done(); fl = m_flush();
        ewe = hdn && !mq[0].exc && mq[0].kind == 0;
        esw = hdn && !mq[0].exc && mq[0].kind == 1;
        check(disp_ready == (mq.size() < DEPTH && !fl), "R3", "disp_ready", disp_ready, mq.size() < DEPTH && !fl);
        check(int'(disp_tag) == ntag, "R2", "disp_tag", disp_tag, ntag);
        check(rf_we == ewe, "R5", "rf_we", rf_we, ewe);
        if (ewe) begin
            check(int'(rf_waddr) == mq[0].dest % NREGS, "R5", "rf_waddr", rf_waddr, mq[0].dest % NREGS);
            check(rf_wdata == 32'(mq[0].val), "R5", "rf_wdata", rf_wdata, 32'(mq[0].val));
        end
        check(st_we == esw, "R6", "st_we", st_we, esw);
        if (esw) begin
            check(int'(st_addr) == mq[0].dest, "R6", "st_addr", st_addr, mq[0].dest);
            check(st_data == 32'(mq[0].val), "R6", "st_data", st_data, 32'(mq[0].val));
        end
        check(flush == fl, "R9", "flush", flush, fl);
        check(exc_raise == (hdn && mq[0].exc), "R10", "exc_raise", exc_raise, hdn && mq[0].exc);
        r = rat[int'(src_reg)];
        check(src_pending == (r >= 0), "R7", "src_pending", src_pending, r >= 0);
        if (r >= 0) begin
            bit rd = 0; int v = 0;
            foreach (mq[i]) if (mq[i].tag == r) begin rd = mq[i].rdy; v = mq[i].val; end
            check(int'(src_tag) == r, "R7", "src_tag", src_tag, r);
            check(src_ready == rd, "R7", "src_ready", src_ready, rd);
            if (rd) check(src_value == 32'(v), "R7", "src_value", src_value, 32'(v));
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (rst_n) model_update(); else model_reset();
        @(negedge clk);
        if (rst_n) compare();
        disp_valid = 0; wb_valid = 0; wb_exc = 0; wb_mispred = 0;
    endtask

    task automatic disp(int kind, int dest);
        disp_valid = 1; disp_kind = 2'(kind); disp_dest = ADDR_W'(dest); step();
    endtask

    task automatic wb(int tag, int val, bit e, bit m);
        wb_valid = 1; wb_tag = TAG_W'(tag); wb_value = 32'(val); wb_exc = e; wb_mispred = m; step();
    endtask

    initial begin
        model_reset();
        repeat (3) step();
        @(negedge clk); rst_n = 1;
        #0.1;
        check(disp_ready == 1, "R1", "reset disp_ready", disp_ready, 1);
        check(disp_tag == 0, "R1", "reset disp_tag", disp_tag, 0);
        check(!rf_we && !st_we && !flush && !exc_raise, "R1", "reset strobes", {rf_we, st_we, flush, exc_raise}, 0);
        check(src_pending == 0, "R1", "reset lookup", src_pending, 0);

        disp(0, 3); check(disp_tag == 1, "R2", "next tag", disp_tag, 1);
        disp(0, 5); disp(1, 'h40); src_reg = 3; disp(0, 3);
        check(src_pending && src_tag == 3 && !src_ready, "R7", "newest producer r3", src_tag, 3);
        src_reg = 5; wb(1, 'h55, 0, 0);
        check(rf_we == 0, "R4", "younger waits behind head", rf_we, 0);
        check(src_ready && src_value == 'h55, "R7", "completed value forwarded", src_value, 'h55);
        wb(0, 'h11, 0, 0);
        check(rf_we && rf_waddr == 3 && rf_wdata == 'h11, "R5", "head register write", rf_wdata, 'h11);
        src_reg = 3; step();
        check(rf_we && rf_waddr == 5, "R4", "next slot retires next cycle", rf_waddr, 5);
        check(src_pending && src_tag == 3, "R8", "younger producer kept", src_tag, 3);
        src_reg = 5; step();
        check(src_pending == 0, "R8", "retired producer cleared", src_pending, 0);
        wb(2, 'h99, 0, 0);
        check(st_we && !rf_we && st_addr == 'h40 && st_data == 'h99, "R6", "store commit", st_data, 'h99);
        wb(3, 'h33, 0, 0); step(); step();

        disp(2, 0);
        for (int i = 0; i < 7; i++) disp(0, 8 + i);
        check(disp_ready == 0, "R3", "full buffer", disp_ready, 0);
        disp(0, 20);
        check(disp_tag == 4, "R3", "dispatch ignored when full", disp_tag, 4);
        src_reg = 10; wb(4, 0, 0, 1);
        check(flush && !rf_we, "R9", "mispredict flush", flush, 1);
        step();
        check(disp_tag == 0 && disp_ready && !src_pending, "R9", "empty after flush", disp_tag, 0);

        disp(0, 7); wb(0, 'h77, 1, 0);
        check(exc_raise && flush && !rf_we, "R10", "precise exception", exc_raise, 1);
        step();
        disp(2, 0); wb(0, 0, 0, 0);
        check(!flush && !rf_we && !st_we, "R11", "good branch retires quietly", flush, 0);
        step();
        check(disp_tag == 1, "R11", "branch slot consumed", disp_tag, 1);

        for (int c = 0; c < 3000; c++) begin
            int pend[$];
            disp_valid = ($urandom % 3) != 0;
            disp_kind = 2'($urandom % 3);
            disp_dest = (disp_kind == 0) ? ADDR_W'($urandom % NREGS) : ADDR_W'($urandom);
            src_reg = REG_W'($urandom);
            foreach (mq[i]) if (!mq[i].rdy) pend.push_back(i);
            if (pend.size() > 0 && ($urandom % 2)) begin
                int k = pend[$urandom % pend.size()];
                wb_valid = 1; wb_tag = TAG_W'(mq[k].tag); wb_value = $urandom;
                wb_exc = ($urandom % 60) == 0;
                wb_mispred = mq[k].kind == 2 && ($urandom % 4) == 0;
            end
            step();
        end

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule